// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit connects a 32-bit core to a word-wide, little-endian, byte-addressed data memory. The core gives it one request per cycle: a base register value, a signed 16-bit displacement, an access size, a load/store direction, a signedness flag for loads and the register value to store. The unit adds base and displacement to form the byte address. It checks that the address is aligned for the requested size, and presents a word-aligned address with per-lane byte enables to the memory one cycle later. For stores it also presents the write data, copied onto every lane the access could use.

For loads, the memory returns the whole word one cycle after the request reaches it. The unit uses the low address bits of that load to shift the wanted byte, halfword or word down to bit 0. It then sign-extends or zero-extends the value to 32 bits. The request path and the load-return path are separate pipeline registers, so a new request can be accepted while an earlier load is still returning its data. A misaligned access raises an error flag and produces no memory traffic.

Top module: `lsu_lane_align`

## Requirements
- R1: The effective address is req_base plus req_offset sign-extended to 32 bits, wrapping modulo 2^32. One cycle after a request, mem_addr holds that address with bits 1:0 cleared.
- R2: The req_size encoding is 00 for a byte, 01 for a halfword and 10 for a word. The code 11 is illegal and is treated exactly like a misaligned access.
- R3: A halfword needs effective-address bit 0 clear, and a word needs bits 1:0 clear. A byte is never misaligned. One cycle after a misaligned request, misalign is 1 and mem_req, mem_we and mem_be are all 0, so memory is left unchanged.
- R4: For an aligned request, mem_be one cycle later is 0001 shifted left by address bits 1:0 for a byte, 0011 shifted left by bits 1:0 for a halfword, and 1111 for a word. This holds for loads and stores alike. mem_req is 1, and mem_we equals req_store.
- R5: mem_wdata carries bits 7:0 of req_wdata on every lane for a byte store, and bits 15:0 of req_wdata on both halves for a halfword store. For a word store it carries req_wdata unchanged.
- R6: Two cycles after an aligned load request, ld_data takes bytes from mem_rdata in little-endian order. The lowest byte of the result is lane (address bits 1:0), where lane k is mem_rdata bits 8k+7:8k.
- R7: When req_signed is 1, byte and halfword loads are sign-extended to 32 bits. When req_signed is 0, they are zero-extended. A word load is not affected by req_signed.
- R8: ld_valid is 1 exactly two cycles after an aligned load request. It is never 1 for a store or for a misaligned request. ld_data is 0 whenever ld_valid is 0.
- R9: While rst_n is low, every output is 0.
- R10: A new request is accepted every cycle. A load result and the memory-side outputs of the request that follows it appear in the same cycle without disturbing each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code (R2) |
| req_signed | input | 1 | Sign-extend load result |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_wdata | input | 32 | Register value to store |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Per-lane byte enables |
| mem_wdata | output | 32 | Lane-steered store data |
| mem_rdata | input | 32 | Word returned by memory, one cycle after mem_req |
| misalign | output | 1 | Misaligned or illegal-size request |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Aligned and extended load result |

## Verification
Two functions can land in the same cycle. One is the load-return path delivering a result; the other is the request path driving a new store's byte enables and write strobe. The bench provokes this by issuing a word load and a byte store on consecutive cycles, then checking in one sample that ld_data holds the old word while mem_we and a single-lane mem_be belong to the store. A later word load confirms that only the intended byte changed. Misalignment and lane steering also coincide within each request: misaligned stores are judged on both the flag and the all-zero enables, and afterwards a load of the same word shows that memory was left untouched.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;

   // Access size codes carried on req_size
   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_RSVD = 2'b11
   } acc_size_e;

   // Register (and largest access) width in bits and bytes
   localparam int REG_W      = 32;
   localparam int REG_BYTES  = REG_W / 8;

   // Number of bytes touched by a size code
   function automatic int unsigned size_bytes(acc_size_e s);
      case (s)
         SZ_BYTE: return 1;
         SZ_HALF: return 2;
         default: return REG_BYTES;
      endcase
   endfunction

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
   import lsu_lane_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int OFFS_W = 16,
   parameter int LB     = 2
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [OFFS_W-1:0] offset,
   input  acc_size_e         size,
   output logic [ADDR_W-1:0] word_addr,
   output logic [LB-1:0]     lane_off,
   output logic              aligned
);

   localparam int EXT_W = ADDR_W - OFFS_W;

   logic [ADDR_W-1:0] ea;

   assign ea        = base + {{EXT_W{offset[OFFS_W-1]}}, offset};
   assign word_addr = {ea[ADDR_W-1:LB], {LB{1'b0}}};
   assign lane_off  = ea[LB-1:0];

   always_comb begin
      case (size)
         SZ_BYTE: aligned = 1'b1;
         SZ_HALF: aligned = ~ea[0];
         SZ_WORD: aligned = (ea[1:0] == 2'b00);
         default: aligned = 1'b0;
      endcase
   end

endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
   import lsu_lane_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LB     = 2
) (
   input  acc_size_e           size,
   input  logic [LB-1:0]       lane_off,
   input  logic [REG_W-1:0]    wdata,
   output logic [DATA_W/8-1:0] be,
   output logic [DATA_W-1:0]   data
);

   localparam int LANES = DATA_W / 8;
   localparam int CW    = LB + 2;

   logic [CW-1:0] first;
   logic [CW-1:0] last_x;

   assign first  = {2'b00, lane_off};
   assign last_x = first + CW'(size_bytes(size));

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam logic [CW-1:0] LI = CW'(i);
      assign be[i] = (LI >= first) && (LI < last_x);
      assign data[8*i +: 8] = (size == SZ_BYTE) ? wdata[7:0] :
                              (size == SZ_HALF) ? wdata[8*(i%2) +: 8] :
                                                  wdata[8*(i%REG_BYTES) +: 8];
   end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
   import lsu_lane_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LB     = 2
) (
   input  logic [DATA_W-1:0] rdata,
   input  logic [LB-1:0]     lane_off,
   input  acc_size_e         size,
   input  logic              sgn,
   output logic [REG_W-1:0]  data
);

   logic [DATA_W-1:0] shifted;

   assign shifted = rdata >> {lane_off, 3'b000};

   always_comb begin
      case (size)
         SZ_BYTE: data = {{(REG_W-8){sgn & shifted[7]}}, shifted[7:0]};
         SZ_HALF: data = {{(REG_W-16){sgn & shifted[15]}}, shifted[15:0]};
         default: data = shifted[REG_W-1:0];
      endcase
   end

endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
   import lsu_lane_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int OFFS_W = 16,
   parameter int DATA_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_store,
   input  logic [1:0]          req_size,
   input  logic                req_signed,
   input  logic [ADDR_W-1:0]   req_base,
   input  logic [OFFS_W-1:0]   req_offset,
   input  logic [REG_W-1:0]    req_wdata,
   output logic                mem_req,
   output logic                mem_we,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [DATA_W/8-1:0] mem_be,
   output logic [DATA_W-1:0]   mem_wdata,
   input  logic [DATA_W-1:0]   mem_rdata,
   output logic                misalign,
   output logic                ld_valid,
   output logic [REG_W-1:0]    ld_data
);

   localparam int LANES = DATA_W / 8;
   localparam int LB    = $clog2(LANES);

   // Elaboration-time parameter checks
   if (DATA_W < REG_W || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data_w
      $error("lsu_lane_align: DATA_W must be a power of two of at least 32");
   end
   if (OFFS_W < 1 || OFFS_W >= ADDR_W) begin : g_bad_offs_w
      $error("lsu_lane_align: OFFS_W must lie between 1 and ADDR_W-1");
   end
   if (ADDR_W <= LB) begin : g_bad_addr_w
      $error("lsu_lane_align: ADDR_W too small for the lane count");
   end

   acc_size_e           sz;
   logic [ADDR_W-1:0]   word_addr;
   logic [LB-1:0]       lane_off;
   logic                aligned;
   logic [LANES-1:0]    st_be;
   logic [DATA_W-1:0]   st_data;
   logic                go;

   assign sz = acc_size_e'(req_size);
   assign go = req_valid & aligned;

   lsu_agen #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .LB(LB)) u_agen (
      .base      (req_base),
      .offset    (req_offset),
      .size      (sz),
      .word_addr (word_addr),
      .lane_off  (lane_off),
      .aligned   (aligned)
   );

   lsu_store_lanes #(.DATA_W(DATA_W), .LB(LB)) u_store (
      .size     (sz),
      .lane_off (lane_off),
      .wdata    (req_wdata),
      .be       (st_be),
      .data     (st_data)
   );

   // Request stage: drives the memory side
   logic          s1_load;
   logic [LB-1:0] s1_off;
   acc_size_e     s1_size;
   logic          s1_sgn;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_req   <= 1'b0;
         mem_we    <= 1'b0;
         mem_be    <= '0;
         mem_addr  <= '0;
         mem_wdata <= '0;
         misalign  <= 1'b0;
         s1_load   <= 1'b0;
         s1_off    <= '0;
         s1_size   <= SZ_BYTE;
         s1_sgn    <= 1'b0;
      end else begin
         mem_req  <= go;
         mem_we   <= go & req_store;
         mem_be   <= go ? st_be : '0;
         misalign <= req_valid & ~aligned;
         s1_load  <= go & ~req_store;
         if (req_valid) begin
            mem_addr  <= word_addr;
            mem_wdata <= st_data;
            s1_off    <= lane_off;
            s1_size   <= sz;
            s1_sgn    <= req_signed;
         end
      end
   end

   // Return stage: lines up with the word coming back from memory
   logic          s2_load;
   logic [LB-1:0] s2_off;
   acc_size_e     s2_size;
   logic          s2_sgn;
   logic [REG_W-1:0] ext;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_load <= 1'b0;
         s2_off  <= '0;
         s2_size <= SZ_BYTE;
         s2_sgn  <= 1'b0;
      end else begin
         s2_load <= s1_load;
         if (s1_load) begin
            s2_off  <= s1_off;
            s2_size <= s1_size;
            s2_sgn  <= s1_sgn;
         end
      end
   end

   lsu_load_extract #(.DATA_W(DATA_W), .LB(LB)) u_load (
      .rdata    (mem_rdata),
      .lane_off (s2_off),
      .size     (s2_size),
      .sgn      (s2_sgn),
      .data     (ext)
   );

   assign ld_valid = s2_load;
   assign ld_data  = s2_load ? ext : '0;

endmodule

// File: rtl/lsu_lane_align_chk.sv
module lsu_lane_align_chk #(
   parameter int DATA_W = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic [1:0]          req_size,
   input logic                req_signed,
   input logic                mem_req,
   input logic                mem_we,
   input logic [DATA_W/8-1:0] mem_be,
   input logic [DATA_W-1:0]   mem_wdata,
   input logic                misalign,
   input logic                ld_valid,
   input logic [31:0]         ld_data
);

   localparam int LANES = DATA_W / 8;

   // R3: a flagged request produces no memory traffic
   a_r3_misalign_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      misalign |-> (!mem_req && !mem_we && mem_be == '0));

   // R3: a byte request is never flagged
   a_r3_byte_never_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_valid && req_size == 2'b00) |-> !misalign);

   // R2: the illegal size code is always flagged
   a_r2_rsvd_flagged: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_valid && req_size == 2'b11) |-> misalign);

   // R4: an issued access enables at least one lane
   a_r4_be_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_be != '0);

   // R5: byte store data is the same on every lane
   a_r5_byte_replicated: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(req_size == 2'b00)) |-> mem_wdata == {LANES{mem_wdata[7:0]}});

   // R8: a load result follows a memory read issued the cycle before
   a_r8_ld_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid |-> $past(mem_req && !mem_we));

   // R8: result bus is quiet while no result is valid
   a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_valid |-> ld_data == 32'h0);

   // R7: unsigned byte loads have clear upper bits
   a_r7_byte_zext: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && $past(req_size == 2'b00 && !req_signed, 2)) |-> ld_data[31:8] == 24'h0);

endmodule

bind lsu_lane_align lsu_lane_align_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_size   (req_size),
   .req_signed (req_signed),
   .mem_req    (mem_req),
   .mem_we     (mem_we),
   .mem_be     (mem_be),
   .mem_wdata  (mem_wdata),
   .misalign   (misalign),
   .ld_valid   (ld_valid),
   .ld_data    (ld_data)
);

// File: tb/lsu_lane_align_tb.sv
module lsu_lane_align_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_store = 1'b0;
   logic [1:0]  req_size = 2'b00;
   logic        req_signed = 1'b0;
   logic [31:0] req_base = '0;
   logic [15:0] req_offset = '0;
   logic [31:0] req_wdata = '0;
   logic        mem_req, mem_we, misalign, ld_valid;
   logic [31:0] mem_addr, mem_wdata, ld_data;
   logic [3:0]  mem_be;
   logic [31:0] mem_rdata = '0;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   lsu_lane_align u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
      .req_size(req_size), .req_signed(req_signed), .req_base(req_base),
      .req_offset(req_offset), .req_wdata(req_wdata), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .misalign(misalign), .ld_valid(ld_valid), .ld_data(ld_data)
   );

   // Behavioural word memory, one-cycle read latency
   logic [31:0] mem [logic [31:0]];

   always @(posedge clk) begin
      if (mem_req) begin
         logic [31:0] w;
         w = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
         if (mem_we) begin
            for (int k = 0; k < 4; k++)
               if (mem_be[k]) w[8*k +: 8] = mem_wdata[8*k +: 8];
            mem[mem_addr] = w;
         end else begin
            mem_rdata <= w;
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   typedef struct packed {
      logic [1:0]  sz;
      logic [31:0] base;
      logic [15:0] ofs;
      logic [31:0] wd;
      logic [31:0] e_addr;
      logic [3:0]  e_be;
      logic        e_mis;
      logic [31:0] e_wd;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{2'd2, 32'h0000_1000, 16'h0000, 32'h5A13_F87C, 32'h0000_1000, 4'hF, 1'b0, 32'h5A13_F87C},
      '{2'd2, 32'h0000_1010, 16'hFFF4, 32'h1234_5678, 32'h0000_1004, 4'hF, 1'b0, 32'h1234_5678},
      '{2'd1, 32'h0000_1000, 16'h0006, 32'hCAFE_9ABC, 32'h0000_1004, 4'hC, 1'b0, 32'h9ABC_9ABC},
      '{2'd0, 32'h0000_1004, 16'h0001, 32'hFFFF_FFE1, 32'h0000_1004, 4'h2, 1'b0, 32'hE1E1_E1E1},
      '{2'd2, 32'h0000_1004, 16'h0002, 32'hDEAD_BEEF, 32'h0000_1004, 4'h0, 1'b1, 32'hDEAD_BEEF},
      '{2'd1, 32'h0000_1004, 16'h0001, 32'h0000_FFFF, 32'h0000_1004, 4'h0, 1'b1, 32'hFFFF_FFFF},
      '{2'd0, 32'h0000_1008, 16'h0003, 32'h0000_0080, 32'h0000_1008, 4'h8, 1'b0, 32'h8080_8080},
      '{2'd1, 32'h0000_1008, 16'h0000, 32'h0000_7FFF, 32'h0000_1008, 4'h3, 1'b0, 32'h7FFF_7FFF},
      '{2'd3, 32'h0000_1008, 16'h0000, 32'h1111_1111, 32'h0000_1008, 4'h0, 1'b1, 32'h1111_1111},
      '{2'd2, 32'hFFFF_FFFE, 16'h0006, 32'h0102_0304, 32'h0000_0004, 4'hF, 1'b0, 32'h0102_0304},
      '{2'd0, 32'h0000_8000, 16'h8000, 32'h0000_0055, 32'h0000_0000, 4'h1, 1'b0, 32'h5555_5555}
   };

   task automatic do_load(input logic [1:0] sz, input logic sg, input logic [31:0] base,
                          input logic [15:0] ofs, input logic [3:0] e_be,
                          input logic e_mis, input logic [31:0] e_data, input string tag);
      @(negedge clk);
      req_valid = 1'b1; req_store = 1'b0; req_size = sz; req_signed = sg;
      req_base = base; req_offset = ofs; req_wdata = 32'h0;
      @(negedge clk);
      req_valid = 1'b0;
      chk({tag, " R4 load be"}, {28'h0, mem_be}, {28'h0, e_be});
      chk({tag, " R3 flag"}, {31'h0, misalign}, {31'h0, e_mis});
      chk({tag, " R4 we"}, {31'h0, mem_we}, 32'h0);
      @(negedge clk);
      chk({tag, " R8 ld_valid"}, {31'h0, ld_valid}, {31'h0, ~e_mis});
      chk({tag, " data"}, ld_data, e_data);
   endtask

   initial begin
      // R9: reset state, with a request held on the inputs
      req_valid = 1'b1; req_store = 1'b1; req_size = 2'b10; req_wdata = 32'hFFFF_FFFF;
      repeat (3) @(negedge clk);
      chk("R9 mem_req", {31'h0, mem_req}, 32'h0);
      chk("R9 mem_we", {31'h0, mem_we}, 32'h0);
      chk("R9 mem_be", {28'h0, mem_be}, 32'h0);
      chk("R9 mem_addr", mem_addr, 32'h0);
      chk("R9 mem_wdata", mem_wdata, 32'h0);
      chk("R9 misalign", {31'h0, misalign}, 32'h0);
      chk("R9 ld_valid", {31'h0, ld_valid}, 32'h0);
      chk("R9 ld_data", ld_data, 32'h0);
      req_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;

      // Store vector table: R1 address, R4 enables, R3/R2 flag, R5 data
      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         req_valid = 1'b1; req_store = 1'b1; req_signed = 1'b0;
         req_size = VECS[v].sz; req_base = VECS[v].base;
         req_offset = VECS[v].ofs; req_wdata = VECS[v].wd;
         @(negedge clk);
         req_valid = 1'b0;
         chk($sformatf("R1 addr vec %0d", v), mem_addr, VECS[v].e_addr);
         chk($sformatf("R4 be vec %0d", v), {28'h0, mem_be}, {28'h0, VECS[v].e_be});
         chk($sformatf("R2 R3 flag vec %0d", v), {31'h0, misalign}, {31'h0, VECS[v].e_mis});
         chk($sformatf("R3 req vec %0d", v), {30'h0, mem_req, mem_we},
             VECS[v].e_mis ? 32'h0 : 32'h3);
         chk($sformatf("R5 wdata vec %0d", v), mem_wdata, VECS[v].e_wd);
         @(negedge clk);
         chk($sformatf("R8 no result after store vec %0d", v), {31'h0, ld_valid}, 32'h0);
      end

      // Loads: R6 lane selection, R7 extension, R1 wrap
      do_load(2'd1, 1'b1, 32'h1000, 16'h0000, 4'h3, 1'b0, 32'hFFFF_F87C, "R7 signed half");
      do_load(2'd1, 1'b0, 32'h1000, 16'h0000, 4'h3, 1'b0, 32'h0000_F87C, "R7 unsigned half");
      do_load(2'd0, 1'b1, 32'h1000, 16'h0002, 4'h4, 1'b0, 32'h0000_0013, "R6 byte lane2");
      do_load(2'd0, 1'b1, 32'h1000, 16'h0001, 4'h2, 1'b0, 32'hFFFF_FFF8, "R7 signed byte");
      do_load(2'd0, 1'b0, 32'h1000, 16'h0001, 4'h2, 1'b0, 32'h0000_00F8, "R7 unsigned byte");
      do_load(2'd2, 1'b0, 32'h1000, 16'h0000, 4'hF, 1'b0, 32'h5A13_F87C, "R6 word");
      do_load(2'd1, 1'b1, 32'h1000, 16'h0002, 4'hC, 1'b0, 32'h0000_5A13, "R6 upper half");
      do_load(2'd2, 1'b1, 32'h1004, 16'h0000, 4'hF, 1'b0, 32'h9ABC_E178, "R3 R7 word after merges");
      do_load(2'd2, 1'b0, 32'h1008, 16'h0000, 4'hF, 1'b0, 32'h8000_7FFF, "R6 word 1008");
      do_load(2'd0, 1'b1, 32'h1008, 16'h0003, 4'h8, 1'b0, 32'hFFFF_FF80, "R7 signed byte lane3");
      do_load(2'd1, 1'b0, 32'h1008, 16'h0002, 4'hC, 1'b0, 32'h0000_8000, "R7 unsigned half lane2");
      do_load(2'd1, 1'b1, 32'h1008, 16'h0002, 4'hC, 1'b0, 32'hFFFF_8000, "R7 signed half lane2");
      do_load(2'd2, 1'b0, 32'h0004, 16'h0000, 4'hF, 1'b0, 32'h0102_0304, "R1 wrapped store");
      do_load(2'd0, 1'b0, 32'h0010, 16'hFFF0, 4'h1, 1'b0, 32'h0000_0055, "R1 negative offset");
      do_load(2'd2, 1'b0, 32'h1002, 16'h0000, 4'h0, 1'b1, 32'h0000_0000, "R8 misaligned load");
      do_load(2'd3, 1'b0, 32'h1000, 16'h0000, 4'h0, 1'b1, 32'h0000_0000, "R2 illegal size load");

      // R10: back-to-back word load then byte store
      @(negedge clk);
      req_valid = 1'b1; req_store = 1'b0; req_size = 2'd2; req_signed = 1'b0;
      req_base = 32'h1000; req_offset = 16'h0000;
      @(negedge clk);
      req_store = 1'b1; req_size = 2'd0; req_base = 32'h1008;
      req_offset = 16'h0001; req_wdata = 32'h0000_0033;
      chk("R10 load issued", {30'h0, mem_req, mem_we}, 32'h2);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R10 ld_valid with store", {31'h0, ld_valid}, 32'h1);
      chk("R10 ld_data with store", ld_data, 32'h5A13_F87C);
      chk("R10 store we", {31'h0, mem_we}, 32'h1);
      chk("R10 store be", {28'h0, mem_be}, 32'h2);
      do_load(2'd2, 1'b0, 32'h1008, 16'h0000, 4'hF, 1'b0, 32'h8000_33FF, "R10 merged word");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      done = 1'b1;
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule